// File: doc/BRIEF.md
# Address-Decoded Fetch/Store Bus

This block joins one requesting master to a set of memory-mapped slaves over a shared bus that knows only two kinds of transfer: fetch, which reads a value, and store, which writes one. The master presents an address, a direction flag and, for a store, a write value. It holds all of them steady until the bus returns a single-cycle completion pulse. Every device action, whether it moves data or only controls the device, has to be written as a fetch or a store to some address.

Each slave owns one contiguous window of the address space, set by a base and a size parameter, and the windows must not overlap. While a transfer is in flight, the decoder raises the select line of the slave whose window holds the address. It then waits for that slave's acknowledge and returns the slave's read data on a fetch. Addresses that fall outside every window are holes. An access to a hole, fetch or store, never reaches a slave. It ends after a fixed timeout with the error flag set and zero read data. The result flag and the read data are registered, and they are non-zero only during the completion cycle.

Top module: `fsb_top`

## Requirements
- R1: While reset is asserted and in the cycles that follow its release, m_done, m_err, m_rdata and slv_sel are all zero.
- R2: During an accepted transfer, slv_sel has at most one bit set. Bit i is set exactly when base_i <= m_addr < base_i + size_i, with slave 0 at bit 0 of slv_sel.
- R3: slv_sel is zero whenever no transfer is in its active phase, including the completion cycle in which m_done is high.
- R4: A fetch to a mapped address completes with m_done high on the rising edge after the first edge at which the selected slave's slv_ack is sampled high. It returns that slave's slv_rdata slice on m_rdata with m_err low.
- R5: A store to a mapped address drives slv_write high and slv_wdata equal to m_wdata while the slave is selected. It completes with the same timing as R4, with m_err low and m_rdata zero.
- R6: A fetch or store to an address in no window never raises any slv_sel bit. It completes with m_err high and m_rdata zero, with m_done rising on the 17th rising edge, counting the edge that accepts the request as the first.
- R7: m_done is high for exactly one cycle. A request still held high during that cycle is not accepted again. A request presented in the following cycle is accepted normally.
- R8: slv_ack from a slave that is not selected has no effect: it neither shortens a hole timeout nor completes a transfer to another slave.
- R9: In any cycle where m_done is low, m_err is low and m_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request, held until m_done |
| m_write | input | 1 | 1 = store, 0 = fetch |
| m_addr | input | ADDR_W | Transfer address |
| m_wdata | input | DATA_W | Store value |
| m_done | output | 1 | One-cycle completion pulse |
| m_err | output | 1 | Hole access, valid with m_done |
| m_rdata | output | DATA_W | Fetch result, valid with m_done |
| slv_sel | output | NUM_SLV | One-hot slave select |
| slv_write | output | 1 | Direction seen by slaves |
| slv_addr | output | ADDR_W | Address seen by slaves |
| slv_wdata | output | DATA_W | Store value seen by slaves |
| slv_ack | input | NUM_SLV | Per-slave acknowledge |
| slv_rdata | input | NUM_SLV*DATA_W | Per-slave read data, slave 0 in the low slice |

## Verification
The assertions check, on every cycle, the properties that hold without looking at the address: the select is never more than one-hot, it is quiet during completion, m_done is a single-cycle pulse, an acknowledged select always finishes without error, an error never follows a select, and the result outputs are zero outside completion. Which slave the address picks, the returned data, the exact completion latency per slave, and the 17-edge hole timeout depend on the address map and the slave timing. Only the bench's sweeps over every address, for stores and for fetches, can show these, together with its stray-acknowledge and back-to-back scenarios.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } fsb_state_e;
endpackage

// File: rtl/fsb_rst_sync.sv
module fsb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fsb_decoder.sv
module fsb_decoder #(
  parameter int ADDR_W  = 16,
  parameter int NUM_SLV = 3,
  parameter logic [NUM_SLV*ADDR_W-1:0]     REG_BASE = '0,
  parameter logic [NUM_SLV*(ADDR_W+1)-1:0] REG_SIZE = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_SLV-1:0] hit,
  output logic               miss
);
  for (genvar i = 0; i < NUM_SLV; i++) begin : g_win
    localparam logic [ADDR_W:0] LO = {1'b0, REG_BASE[i*ADDR_W +: ADDR_W]};
    localparam logic [ADDR_W:0] HI = LO + REG_SIZE[i*(ADDR_W+1) +: (ADDR_W+1)];
    logic [ADDR_W:0] a_ext;
    assign a_ext  = {1'b0, addr};
    assign hit[i] = (a_ext >= LO) && (a_ext < HI);
  end

  assign miss = ~|hit;
endmodule

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
  import fsb_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic miss,
  input  logic ack_hit,
  output logic busy,
  output logic finish,
  output logic finish_err
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  fsb_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cnt_en     = 1'b0;
    finish     = 1'b0;
    finish_err = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d = ST_BUSY;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      ST_BUSY: begin
        if (miss) begin
          if (cnt_q == CNT_LAST) begin
            finish     = 1'b1;
            finish_err = 1'b1;
            state_d    = ST_DONE;
          end else begin
            cnt_en = 1'b1;
            cnt_d  = cnt_q + 1'b1;
          end
        end else if (ack_hit) begin
          finish  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (state_q == ST_BUSY);
endmodule

// File: rtl/fsb_resp.sv
module fsb_resp #(
  parameter int DATA_W  = 32,
  parameter int NUM_SLV = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      finish,
  input  logic                      finish_err,
  input  logic                      write,
  input  logic [NUM_SLV-1:0]        hit,
  input  logic [NUM_SLV*DATA_W-1:0] slv_rdata,
  output logic                      done,
  output logic                      err,
  output logic [DATA_W-1:0]         rdata
);
  logic [DATA_W-1:0] mux;
  logic [DATA_W-1:0] rdata_d;
  logic              rd_en;
  logic              err_d;

  always_comb begin
    mux = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (hit[i]) mux = slv_rdata[i*DATA_W +: DATA_W];
    end
  end

  assign err_d   = finish & finish_err;
  assign rdata_d = (finish && !finish_err && !write) ? mux : '0;
  assign rd_en   = finish | done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= finish;
      err  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end
endmodule

// File: rtl/fsb_top.sv
module fsb_top #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_SLV = 3,
  parameter logic [NUM_SLV*ADDR_W-1:0]     REG_BASE = {16'h8000, 16'h1000, 16'h0000},
  parameter logic [NUM_SLV*(ADDR_W+1)-1:0] REG_SIZE = {17'h00100, 17'h01000, 17'h00400},
  parameter int HOLE_TIMEOUT = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      m_req,
  input  logic                      m_write,
  input  logic [ADDR_W-1:0]         m_addr,
  input  logic [DATA_W-1:0]         m_wdata,
  output logic                      m_done,
  output logic                      m_err,
  output logic [DATA_W-1:0]         m_rdata,
  output logic [NUM_SLV-1:0]        slv_sel,
  output logic                      slv_write,
  output logic [ADDR_W-1:0]         slv_addr,
  output logic [DATA_W-1:0]         slv_wdata,
  input  logic [NUM_SLV-1:0]        slv_ack,
  input  logic [NUM_SLV*DATA_W-1:0] slv_rdata
);
  logic               rst_sync_n;
  logic [NUM_SLV-1:0] hit;
  logic               miss;
  logic               busy;
  logic               finish;
  logic               finish_err;
  logic               ack_hit;

  fsb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsb_decoder #(
    .ADDR_W   (ADDR_W),
    .NUM_SLV  (NUM_SLV),
    .REG_BASE (REG_BASE),
    .REG_SIZE (REG_SIZE)
  ) u_dec (
    .addr (m_addr),
    .hit  (hit),
    .miss (miss)
  );

  assign slv_sel   = hit & {NUM_SLV{busy}};
  assign ack_hit   = |(slv_sel & slv_ack);
  assign slv_write = m_write;
  assign slv_addr  = m_addr;
  assign slv_wdata = m_wdata;

  fsb_ctrl #(
    .TIMEOUT (HOLE_TIMEOUT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req        (m_req),
    .miss       (miss),
    .ack_hit    (ack_hit),
    .busy       (busy),
    .finish     (finish),
    .finish_err (finish_err)
  );

  fsb_resp #(
    .DATA_W  (DATA_W),
    .NUM_SLV (NUM_SLV)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .finish     (finish),
    .finish_err (finish_err),
    .write      (m_write),
    .hit        (hit),
    .slv_rdata  (slv_rdata),
    .done       (m_done),
    .err        (m_err),
    .rdata      (m_rdata)
  );
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
  parameter int NUM_SLV = 3,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SLV-1:0] slv_sel,
  input logic [NUM_SLV-1:0] slv_ack,
  input logic               m_done,
  input logic               m_err,
  input logic [DATA_W-1:0]  m_rdata
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_sel)); // R2

  AST_DONE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |-> (slv_sel == '0)); // R3

  AST_ACK_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (|(slv_sel & slv_ack)) |=> (m_done && !m_err)); // R4

  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> ($past(slv_sel) == '0)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |=> !m_done); // R7

  AST_QUIET_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !m_done |-> (!m_err && (m_rdata == '0))); // R9
endmodule

bind fsb_top fsb_checker #(
  .NUM_SLV (NUM_SLV),
  .DATA_W  (DATA_W)
) u_fsb_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .slv_sel (slv_sel),
  .slv_ack (slv_ack),
  .m_done  (m_done),
  .m_err   (m_err),
  .m_rdata (m_rdata)
);

// File: tb/tb_fsb_top.sv
module tb_fsb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NS = 3;

  logic          clk;
  logic          rst_n;
  logic          m_req, m_write;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic          m_done, m_err;
  logic [DW-1:0] m_rdata;
  logic [NS-1:0] slv_sel;
  logic          slv_write;
  logic [AW-1:0] slv_addr;
  logic [DW-1:0] slv_wdata;
  logic [NS-1:0] slv_ack;
  logic [NS*DW-1:0] slv_rdata;
  logic [NS-1:0] stray;

  int n_cmp = 0;
  int n_bad = 0;

  fsb_top #(
    .ADDR_W       (AW),
    .DATA_W       (DW),
    .NUM_SLV      (NS),
    .REG_BASE     ({6'h30, 6'h10, 6'h04}),
    .REG_SIZE     ({7'd4, 7'd16, 7'd8}),
    .HOLE_TIMEOUT (16)
  ) dut (
    .clk (clk), .rst_n (rst_n),
    .m_req (m_req), .m_write (m_write), .m_addr (m_addr), .m_wdata (m_wdata),
    .m_done (m_done), .m_err (m_err), .m_rdata (m_rdata),
    .slv_sel (slv_sel), .slv_write (slv_write), .slv_addr (slv_addr),
    .slv_wdata (slv_wdata), .slv_ack (slv_ack), .slv_rdata (slv_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Slave models: slave i acknowledges after i wait cycles
  logic [DW-1:0] mem [64];
  logic [3:0]    wcnt [NS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NS; i++) begin
      if (!slv_sel[i] || slv_ack[i]) wcnt[i] <= 4'd0;
      else                           wcnt[i] <= wcnt[i] + 4'd1;
    end
    if (|(slv_sel & slv_ack) && slv_write) mem[slv_addr] <= slv_wdata;
  end

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      slv_ack[i] = (slv_sel[i] && (wcnt[i] == 4'(i))) || stray[i];
      slv_rdata[i*DW +: DW] = mem[slv_addr];
    end
  end

  function automatic int owner(input int a);
    if (a >= 4 && a < 12)  return 0;
    if (a >= 16 && a < 32) return 1;
    if (a >= 48 && a < 52) return 2;
    return -1;
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 16'h0101) ^ 16'h5A3C ^ (k * 16'h1111));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int            t_lat;
  logic          t_err;
  logic [DW-1:0] t_rd;
  logic [NS-1:0] t_sel;
  logic          t_wbad;

  task automatic run_txn(input bit wait_first, input bit wr, input int a,
                         input logic [DW-1:0] wd, input bit hold);
    if (wait_first) @(negedge clk);
    m_req = 1'b1; m_write = wr; m_addr = AW'(a); m_wdata = wd;
    t_lat = 0; t_sel = '0; t_wbad = 1'b0;
    while (1) begin
      @(posedge clk);
      t_lat++;
      @(negedge clk);
      t_sel |= slv_sel;
      if (|slv_sel && (slv_write !== wr || slv_wdata !== wd)) t_wbad = 1'b1;
      if (m_done || t_lat > 60) break;
    end
    t_err = m_err;
    t_rd  = m_rdata;
    chk("R3 select quiet in completion cycle", 32'(slv_sel), 32'd0);
    if (!hold) m_req = 1'b0;
  endtask

  task automatic check_txn(input bit wr, input int a, input logic [DW-1:0] exp_rd);
    int o;
    o = owner(a);
    if (o >= 0) begin
      chk(wr ? "R5 store latency" : "R4 fetch latency", 32'(t_lat), 32'(o + 2));
      chk("R2 select matches owner", 32'(t_sel), 32'(1 << o));
      chk(wr ? "R5 store no error" : "R4 fetch no error", 32'(t_err), 32'd0);
      chk(wr ? "R5 store read data zero" : "R4 fetch data", 32'(t_rd), 32'(exp_rd));
      if (wr) chk("R5 store fields seen by slave", 32'(t_wbad), 32'd0);
    end else begin
      chk("R6 hole latency", 32'(t_lat), 32'd17);
      chk("R6 hole no select", 32'(t_sel), 32'd0);
      chk("R6 hole error", 32'(t_err), 32'd1);
      chk("R6 hole read data zero", 32'(t_rd), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; m_req = 1'b0; m_write = 1'b0; m_addr = '0; m_wdata = '0; stray = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset m_done", 32'(m_done), 32'd0);
    chk("R1 reset m_err", 32'(m_err), 32'd0);
    chk("R1 reset m_rdata", 32'(m_rdata), 32'd0);
    chk("R1 reset slv_sel", 32'(slv_sel), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release m_done", 32'(m_done), 32'd0);
    chk("R3 idle select quiet", 32'(slv_sel), 32'd0);

    // Store sweep over the whole address space
    for (int a = 0; a < 64; a++) begin
      run_txn(1'b1, 1'b1, a, pat(a, 0), 1'b0);
      check_txn(1'b1, a, '0);
    end
    // Fetch sweep over the whole address space
    for (int a = 0; a < 64; a++) begin
      run_txn(1'b1, 1'b0, a, '0, 1'b0);
      check_txn(1'b0, a, (owner(a) >= 0) ? pat(a, 0) : '0);
    end

    // R5 overwrite then read back
    run_txn(1'b1, 1'b1, 16, pat(16, 3), 1'b0);
    check_txn(1'b1, 16, '0);
    run_txn(1'b1, 1'b0, 16, '0, 1'b0);
    check_txn(1'b0, 16, pat(16, 3));

    // R8 stray acknowledges from unselected slaves
    stray = 3'b111;
    run_txn(1'b1, 1'b0, 40, '0, 1'b0);
    check_txn(1'b0, 40, '0);
    stray = 3'b011;
    run_txn(1'b1, 1'b0, 49, '0, 1'b0);
    check_txn(1'b0, 49, pat(49, 0));
    stray = 3'b000;

    // R7 request held through completion, next request right after
    run_txn(1'b1, 1'b1, 0, 16'hBEEF, 1'b1);
    check_txn(1'b1, 0, '0);
    @(negedge clk);
    chk("R7 done is a single-cycle pulse", 32'(m_done), 32'd0);
    chk("R9 error low outside completion", 32'(m_err), 32'd0);
    chk("R9 read data zero outside completion", 32'(m_rdata), 32'd0);
    run_txn(1'b0, 1'b0, 5, '0, 1'b0);
    chk("R7 back-to-back latency", 32'(t_lat), 32'd2);
    chk("R7 back-to-back data", 32'(t_rd), 32'(pat(5, 0)));

    repeat (3) @(negedge clk);
    summary();
  end
endmodule